// File: doc/BRIEF.md
# Firmware Glue Register Block

This block is a small memory-mapped slave that boot firmware uses for a handful of system services. Through one 32-bit register window it can stop the machine with an exit code, learn which processor is running the access and how many processors exist, and drive each processor's level-sensitive interrupt line. It also offers a one-character console: a receive holding register and a transmit register, each paired with a status byte.

Received characters come in on a valid/data pair. A character reaches the holding register only while the receive status is zero. Transmitted characters leave on a one-cycle valid/data pair. Each processor's interrupt line is set by one paired store. The low byte of that store names the processor and the next byte gives the level. Register reads have no side effects, and the read data is combinational from the stored state.

Top module: `fw_glue_regs`

## Requirements
- R1: Only address bits 4:2 select a register word; bits 1:0 and any bits above bit 4 are ignored. Word offsets are: 0 halt, 4 processor ID, 8 interrupt pair, 12 processor count, 16 receive data, 20 receive status, 24 transmit data, 28 transmit status.
- R2: After reset, transmit status is 1, receive status and both data registers are 0, all interrupt lines are 0, and haltReq, txValid and rxOverrun are 0.
- R3: A write to offset 0 with byte lane 0 enabled sets haltReq one cycle later. haltReq then stays high until reset, and exitCode holds the written low byte.
- R4: A read of offset 4 returns cpuId, and a read of offset 12 returns CPU_COUNT.
- R5: A write to offset 8 with lane 0 enabled selects line number wdata[7:0]. That line takes the value 1 if the level byte wdata[15:8] is nonzero and lane 1 is enabled, and 0 otherwise. A line number at or above CPU_COUNT changes nothing, and every line holds its value until it is rewritten.
- R6: When rxValid arrives while receive status is zero, the receive data register takes rxData and receive status becomes 1.
- R7: When rxValid arrives while receive status is nonzero, the character is dropped, the stored data is unchanged, and rxOverrun pulses high for one cycle, starting one cycle later.
- R8: A write to offset 24 raises txValid for exactly one cycle, one cycle later, with txData equal to the written low byte. It also sets transmit status to 1, and offset 24 then reads back that byte.
- R9: A software write to offset 16, 20 or 28 overwrites the stored receive data, receive status or transmit status with the low written byte.
- R10: Read data carries the value in bits 7:0 with bits 31:8 zero. Offsets 0 and 8 read as zero, and busRdata is zero while busRead is low.
- R11: A write with byteEn[0] low, and any write to offset 4 or 12, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busRead | input | 1 | Read enable |
| busByteEn | input | 4 | Byte-lane enables for writes |
| busWdata | input | 32 | Write data, lane 0 in bits 7:0 |
| busRdata | output | 32 | Read data |
| cpuId | input | ID_W | Number of the processor making the access |
| rxValid | input | 1 | Received character strobe |
| rxData | input | 8 | Received character |
| txValid | output | 1 | Transmitted character strobe |
| txData | output | 8 | Transmitted character |
| haltReq | output | 1 | Sticky halt request |
| exitCode | output | 8 | Exit code of the halt request |
| irqLine | output | CPU_COUNT | Interrupt line per processor |
| rxOverrun | output | 1 | Pulse for a dropped received character |

## Verification
The interrupt bank is swept over every line number up to twice the processor count, with nonzero levels, zero levels and single-lane stores. This separates a correct line select from wrong-line or out-of-range updates and shows that the other lines hold their values. The transmit path is driven with all 256 byte values, which exposes any stuck or swapped data bit. The receive path alternates fresh arrivals with arrivals into a full holding register, which separates a load from a drop with overrun. Reads cover every offset, aliased upper address bits, every cpuId value and writes with lane 0 disabled.

// File: rtl/fw_glue_pkg.sv
package fw_glue_pkg;

  typedef enum logic [2:0] {
    SLOT_HALT   = 3'd0,
    SLOT_CPUID  = 3'd1,
    SLOT_IRQ    = 3'd2,
    SLOT_CPUCNT = 3'd3,
    SLOT_RXDATA = 3'd4,
    SLOT_RXSTAT = 3'd5,
    SLOT_TXDATA = 3'd6,
    SLOT_TXSTAT = 3'd7
  } slot_e;

  typedef struct packed {
    logic wrHalt;
    logic wrIrq;
    logic irqUseLevel;
    logic wrRxData;
    logic wrRxStat;
    logic wrTxData;
    logic wrTxStat;
    logic loadRx;
    logic dropRx;
  } ctlStrobes_t;

endpackage

// File: rtl/fw_glue_ctrl.sv
module fw_glue_ctrl
  import fw_glue_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [3:0]        busByteEn,
  input  logic              rxValid,
  input  logic              rxWaiting,
  output slot_e             rdSlot,
  output ctlStrobes_t       strobes
);

  slot_e slot;
  logic  wrLane0;
  logic  swRxTouch;

  assign slot    = slot_e'(busAddr[4:2]);
  assign rdSlot  = slot;
  assign wrLane0 = busWrite && busByteEn[0];

  always_comb begin
    strobes             = '0;
    strobes.wrHalt      = wrLane0 && (slot == SLOT_HALT);
    strobes.wrIrq       = wrLane0 && (slot == SLOT_IRQ);
    strobes.irqUseLevel = busByteEn[1];
    strobes.wrRxData    = wrLane0 && (slot == SLOT_RXDATA);
    strobes.wrRxStat    = wrLane0 && (slot == SLOT_RXSTAT);
    strobes.wrTxData    = wrLane0 && (slot == SLOT_TXDATA);
    strobes.wrTxStat    = wrLane0 && (slot == SLOT_TXSTAT);
    // software access to the receive pair takes precedence over an arrival
    swRxTouch           = strobes.wrRxData || strobes.wrRxStat;
    strobes.loadRx      = rxValid && !rxWaiting && !swRxTouch;
    strobes.dropRx      = rxValid && rxWaiting && !swRxTouch;
  end

endmodule

// File: rtl/fw_glue_dp.sv
module fw_glue_dp
  import fw_glue_pkg::*;
#(
  parameter int CPU_COUNT = 4,
  parameter int ID_W      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  slot_e                rdSlot,
  input  logic                 busRead,
  input  logic [31:0]          busWdata,
  input  logic [ID_W-1:0]      cpuId,
  input  logic [7:0]           rxData,
  output logic                 rxWaiting,
  output logic [31:0]          busRdata,
  output logic                 txValid,
  output logic [7:0]           txData,
  output logic                 haltReq,
  output logic [7:0]           exitCode,
  output logic [CPU_COUNT-1:0] irqLine,
  output logic                 rxOverrun
);

  localparam logic [7:0] CountByte = 8'(CPU_COUNT);

  logic [7:0] rxReg, rxStat, txReg, txStat;
  logic [7:0] wrByte, lvlByte, rdByte;

  assign wrByte    = busWdata[7:0];
  assign lvlByte   = busWdata[15:8];
  assign rxWaiting = (rxStat != 8'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReq  <= 1'b0;
      exitCode <= 8'd0;
    end else if (strobes.wrHalt) begin
      haltReq  <= 1'b1;
      exitCode <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg     <= 8'd0;
      rxStat    <= 8'd0;
      rxOverrun <= 1'b0;
    end else begin
      rxOverrun <= strobes.dropRx;
      if (strobes.wrRxData) rxReg <= wrByte;
      else if (strobes.loadRx) rxReg <= rxData;
      if (strobes.wrRxStat) rxStat <= wrByte;
      else if (strobes.loadRx) rxStat <= 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg   <= 8'd0;
      txStat  <= 8'd1;
      txValid <= 1'b0;
    end else begin
      txValid <= strobes.wrTxData;
      if (strobes.wrTxData) begin
        txReg  <= wrByte;
        txStat <= 8'd1;
      end else if (strobes.wrTxStat) begin
        txStat <= wrByte;
      end
    end
  end

  assign txData = txReg;

  for (genvar g = 0; g < CPU_COUNT; g++) begin : gIrq
    always_ff @(posedge clk) begin
      if (!rstN) irqLine[g] <= 1'b0;
      else if (strobes.wrIrq && (wrByte == 8'(g)) && (wrByte < CountByte))
        irqLine[g] <= strobes.irqUseLevel && (lvlByte != 8'd0);
    end
  end

  always_comb begin
    unique case (rdSlot)
      SLOT_CPUID:  rdByte = 8'(cpuId);
      SLOT_CPUCNT: rdByte = CountByte;
      SLOT_RXDATA: rdByte = rxReg;
      SLOT_RXSTAT: rdByte = rxStat;
      SLOT_TXDATA: rdByte = txReg;
      SLOT_TXSTAT: rdByte = txStat;
      default:     rdByte = 8'd0;
    endcase
  end

  assign busRdata = busRead ? {24'd0, rdByte} : 32'd0;

endmodule

// File: rtl/fw_glue_regs.sv
module fw_glue_regs
  import fw_glue_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CPU_COUNT = 4,
  parameter int ID_W      = (CPU_COUNT > 1) ? $clog2(CPU_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrite,
  input  logic                 busRead,
  input  logic [3:0]           busByteEn,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [ID_W-1:0]      cpuId,
  input  logic                 rxValid,
  input  logic [7:0]           rxData,
  output logic                 txValid,
  output logic [7:0]           txData,
  output logic                 haltReq,
  output logic [7:0]           exitCode,
  output logic [CPU_COUNT-1:0] irqLine,
  output logic                 rxOverrun
);

  ctlStrobes_t strobes;
  slot_e       rdSlot;
  logic        rxWaiting;

  fw_glue_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWrite(busWrite), .busByteEn(busByteEn),
    .rxValid(rxValid), .rxWaiting(rxWaiting),
    .rdSlot(rdSlot), .strobes(strobes)
  );

  fw_glue_dp #(.CPU_COUNT(CPU_COUNT), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSlot(rdSlot),
    .busRead(busRead), .busWdata(busWdata), .cpuId(cpuId), .rxData(rxData),
    .rxWaiting(rxWaiting), .busRdata(busRdata), .txValid(txValid),
    .txData(txData), .haltReq(haltReq), .exitCode(exitCode),
    .irqLine(irqLine), .rxOverrun(rxOverrun)
  );

endmodule

// File: rtl/fw_glue_regs_chk.sv
module fw_glue_regs_chk #(
  parameter int ADDR_W    = 8,
  parameter int CPU_COUNT = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrite,
  input logic                 busRead,
  input logic [3:0]           busByteEn,
  input logic [31:0]          busWdata,
  input logic [31:0]          busRdata,
  input logic                 rxValid,
  input logic                 txValid,
  input logic [7:0]           txData,
  input logic                 haltReq,
  input logic [CPU_COUNT-1:0] irqLine,
  input logic                 rxOverrun
);

  assert_tx_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busByteEn[0] && busAddr[4:2] == 3'd6)
      |=> (txValid && txData == $past(busWdata[7:0])));

  assert_tx_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    txValid |=> !txValid || $past(busWrite));

  assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> haltReq);

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxValid));

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busWrite |=> $stable(irqLine));

  assert_rdata_upper_R10: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[31:8] == 24'd0);

  assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |-> busRdata == 32'd0);

endmodule

bind fw_glue_regs fw_glue_regs_chk #(.ADDR_W(ADDR_W), .CPU_COUNT(CPU_COUNT)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
  .busRead(busRead), .busByteEn(busByteEn), .busWdata(busWdata),
  .busRdata(busRdata), .rxValid(rxValid), .txValid(txValid), .txData(txData),
  .haltReq(haltReq), .irqLine(irqLine), .rxOverrun(rxOverrun)
);

// File: tb/fw_glue_regs_test.sv
module fw_glue_regs_test;

  localparam int ADDR_W = 8;
  localparam int NCPU   = 4;
  localparam int ID_W   = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrite = 1'b0;
  logic              busRead = 1'b0;
  logic [3:0]        busByteEn = 4'h0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic [ID_W-1:0]   cpuId = '0;
  logic              rxValid = 1'b0;
  logic [7:0]        rxData = '0;
  logic              txValid;
  logic [7:0]        txData;
  logic              haltReq;
  logic [7:0]        exitCode;
  logic [NCPU-1:0]   irqLine;
  logic              rxOverrun;

  int total = 0;
  int bad = 0;
  logic [NCPU-1:0] expIrq = '0;

  always #10 clk = ~clk;

  fw_glue_regs #(.ADDR_W(ADDR_W), .CPU_COUNT(NCPU)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busByteEn(busByteEn), .busWdata(busWdata),
    .busRdata(busRdata), .cpuId(cpuId), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .haltReq(haltReq),
    .exitCode(exitCode), .irqLine(irqLine), .rxOverrun(rxOverrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busByteEn = be; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0; busByteEn = 4'h0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRead = 1'b1;
    #1 d = busRdata;
    busRead = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] c);
    @(negedge clk);
    rxValid = 1'b1; rxData = c;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state
    rd(8'd28, r); check("R2 txstat", r, 32'd1);
    rd(8'd20, r); check("R2 rxstat", r, 32'd0);
    rd(8'd16, r); check("R2 rxdata", r, 32'd0);
    rd(8'd24, r); check("R2 txdata", r, 32'd0);
    check("R2 irq", {28'd0, irqLine}, 32'd0);
    check("R2 halt", {31'd0, haltReq}, 32'd0);
    check("R2 txValid", {31'd0, txValid}, 32'd0);

    // R4 processor id and count, with R1 aliasing of upper bits
    for (int i = 0; i < NCPU; i++) begin
      cpuId = ID_W'(i);
      rd(8'd4, r); check("R4 cpuid", r, 32'(i));
      rd(8'hE5, r); check("R1 alias cpuid", r, 32'(i));
    end
    rd(8'd12, r); check("R4 count", r, 32'(NCPU));

    // R10 write-only offsets and idle bus
    rd(8'd0, r); check("R10 off0", r, 32'd0);
    rd(8'd8, r); check("R10 off8", r, 32'd0);
    @(negedge clk); #1 check("R10 idle", busRdata, 32'd0);

    // R5 interrupt sweep over line numbers up to twice the count
    for (int p = 0; p < 2 * NCPU; p++) begin
      wr(8'd8, 4'b0011, {16'd0, 8'(p + 1), 8'(p)});
      if (p < NCPU) expIrq[p] = 1'b1;
      check("R5 set", {28'd0, irqLine}, {28'd0, expIrq});
    end
    for (int p = 0; p < 2 * NCPU; p += 2) begin
      wr(8'd8, 4'b0011, {16'd0, 8'd0, 8'(p)});
      if (p < NCPU) expIrq[p] = 1'b0;
      check("R5 clear", {28'd0, irqLine}, {28'd0, expIrq});
    end
    wr(8'd8, 4'b0001, {16'd0, 8'hFF, 8'd1});
    expIrq[1] = 1'b0;
    check("R5 lane0 only", {28'd0, irqLine}, {28'd0, expIrq});
    wr(8'd8, 4'b0010, {16'd0, 8'hFF, 8'd1});
    check("R11 no lane0 irq", {28'd0, irqLine}, {28'd0, expIrq});
    repeat (4) @(negedge clk);
    check("R5 hold", {28'd0, irqLine}, {28'd0, expIrq});

    // R8 transmit all byte values
    for (int c = 0; c < 256; c++) begin
      if (c == 5) wr(8'd28, 4'b0001, 32'd0);
      wr(8'd24, 4'b0001, 32'(c) | 32'hABCD_0000);
      check("R8 txValid", {31'd0, txValid}, 32'd1);
      check("R8 txData", {24'd0, txData}, 32'(c));
      @(negedge clk);
      check("R8 single", {31'd0, txValid}, 32'd0);
    end
    rd(8'd24, r); check("R8 readback", r, 32'd255);
    rd(8'd28, r); check("R8 status", r, 32'd1);

    // R9 software overwrite of status and data
    wr(8'd28, 4'b1111, 32'h1234_5600);
    rd(8'd28, r); check("R9 txstat", r, 32'd0);
    wr(8'd16, 4'b0001, 32'h0000_00A5);
    rd(8'd16, r); check("R9 rxdata", r, 32'hA5);
    wr(8'd20, 4'b0001, 32'h0000_0000);

    // R6 / R7 receive load and overrun
    for (int i = 0; i < 16; i++) begin
      logic [7:0] c;
      c = 8'(i * 17 + 3);
      rxPush(c);
      check("R7 no overrun", {31'd0, rxOverrun}, 32'd0);
      rd(8'd20, r); check("R6 rxstat", r, 32'd1);
      rd(8'd16, r); check("R6 rxdata", r, 32'(c));
      rxPush(~c);
      check("R7 overrun", {31'd0, rxOverrun}, 32'd1);
      @(negedge clk);
      check("R7 pulse", {31'd0, rxOverrun}, 32'd0);
      rd(8'd16, r); check("R7 kept", r, 32'(c));
      wr(8'd20, 4'b0001, 32'd0);
      rd(8'd20, r); check("R9 rxstat clear", r, 32'd0);
    end

    // R11 writes without lane 0 and to read-only offsets
    wr(8'd16, 4'b1110, 32'hFFFF_FF77);
    rd(8'd16, r); check("R11 rxdata", r, 32'(8'(15 * 17 + 3)));
    wr(8'd4, 4'b1111, 32'h0000_0033);
    wr(8'd12, 4'b1111, 32'h0000_0033);
    rd(8'd12, r); check("R11 count", r, 32'(NCPU));
    wr(8'd0, 4'b1110, 32'h0000_0011);
    check("R11 halt", {31'd0, haltReq}, 32'd0);

    // R3 halt with exit code, via an aliased address (R1)
    wr(8'h60, 4'b0001, 32'h0000_005A);
    check("R3 halt", {31'd0, haltReq}, 32'd1);
    check("R3 code", {24'd0, exitCode}, 32'h5A);
    repeat (3) @(negedge clk);
    check("R3 sticky", {31'd0, haltReq}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule